// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block keeps the address windows of four DRAM chip selects. Each window has a base word and a size word. Both words are written and read through a small 32-bit register port. Physical addresses are 36 bits wide. A window covers a power-of-two multiple of 16 MiB. Its base supplies address bits 35:24, split into a low byte and a high nibble.

A lookup port takes a physical address. One clock later it returns three things: the chip-select number of the winning window, the bus attribute that a device uses to reach that chip select, and a miss flag. The attribute for window i is a one-cold pattern in the low four bits, with bit i cleared. A coherency input adds bit 4.

At the same time the block publishes, without latency, a packed table of the windows that a device limited to 32-bit addresses can reach. A window qualifies when it is enabled and its high base nibble is zero. The qualifying windows are packed from slot 0 upward in window order, and a count goes with the table.

Top module: `dcw_top`

## Requirements
- R1: After reset every register reads zero, the lookup reports a miss with chip select 0 and attribute 0, and the exported count is 0.
- R2: A write to byte offset 8·n sets the base word of window n, and a write to offset 8·n+4 sets its size word. Offset bits 1:0 are ignored. A read at the same offset returns exactly the 32-bit value last written.
- R3: The size word is decoded as follows: bit 0 enables the window, bits 4:2 hold the chip-select number, and bits 31:24 hold (size−1) in 16 MiB units. On a hit, lk_cs returns bits 4:2 of the winning window. The result appears on the clock edge after lk_addr is presented.
- R4: A window covers (size[31:24]+1)×16 MiB starting at its base. The last byte of that span hits, and the first byte past it does not.
- R5: When several enabled windows match, the lowest-numbered one wins.
- R6: If no enabled window matches, lk_miss is 1 and both lk_cs and lk_attr are 0. A disabled window never matches.
- R7: On a hit in window i, lk_attr bits 3:0 are 0xF with bit i cleared, and bit 4 equals coh_en as sampled with the address. Bits 7:5 are zero.
- R8: Address bits 35:32 must equal base word bits 3:0. Address bits 31:24, masked by the inverted size field, must equal base word bits 31:24.
- R9: The exported table holds the windows that are enabled and have base bits 3:0 equal to zero. They are packed in ascending window order into slots 0 to exp_count−1. Slots at or above exp_count are all zero.
- R10: Each exported slot k carries four fields: the window index in exp_idx[2k+1:2k], base bits 31:24 in exp_base[8k+7:8k], the size field in exp_szm[8k+7:8k], and the R7 attribute in exp_attr[8k+7:8k], using the current coh_en.
- R11: A window whose base is not aligned to its own size never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| coh_en | input | 1 | Hardware coherency enable, sets attribute bit 4 |
| lk_addr | input | 36 | Physical address to decode |
| lk_miss | output | 1 | No window matched (registered) |
| lk_cs | output | 3 | Chip-select number of the winning window (registered) |
| lk_attr | output | 8 | Attribute of the winning window (registered) |
| exp_count | output | 3 | Number of exported windows |
| exp_idx | output | 8 | Window index per exported slot, 2 bits each |
| exp_base | output | 32 | Base bits 31:24 per slot |
| exp_szm | output | 32 | Size field per slot |
| exp_attr | output | 32 | Attribute per slot |

## Verification
The lookup is tried at several kinds of address, each of which separates a different fault:
- The first and last byte of each window and the byte just past it, which show an off-by-one in the size mask.
- An address that differs only in bits 35:32, which shows whether the high nibble is compared.
- An address inside an unaligned window, which shows whether the masked compare is done against the unmasked base.

Overlapping windows are looked up before and after the lower window is disabled, which separates priority order from plain matching. The exported table is read under both coherency settings and after a window is disabled, so packing, ordering, zeroing of unused slots and the attribute bits are each seen independently.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
    localparam int REG_W  = 32;
    localparam int PA_W   = 36;
    localparam int CS_W   = 3;
    localparam int ATTR_W = 8;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 4;
    localparam logic [ATTR_W-1:0] ATTR_ALL = 8'h0F;
    localparam int COH_BIT = 4;

    // decoded view of one chip-select window
    typedef struct packed {
        logic              en;
        logic [CS_W-1:0]   cs;
        logic [BYTE_W-1:0] szm;
        logic [BYTE_W-1:0] blo;
        logic [HI_W-1:0]   bhi;
    } win_fields_t;

    function automatic logic [ATTR_W-1:0] cs_attr(input int idx, input logic coh);
        logic [ATTR_W-1:0] a;
        a = ATTR_ALL;
        for (int b = 0; b < 4; b++) begin
            if (b == idx) a[b] = 1'b0;
        end
        a[COH_BIT] = coh;
        return a;
    endfunction
endpackage

// File: rtl/dcw_regs.sv
module dcw_regs
    import dcw_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(NWIN)+2:0]      addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output win_fields_t                  flds [NWIN]
);
    localparam int IDX_W = $clog2(NWIN);
    localparam int OFF_W = IDX_W + 3;

    logic [REG_W-1:0] base_q [NWIN];
    logic [REG_W-1:0] size_q [NWIN];
    logic [IDX_W-1:0] sel;
    logic [1:0]       unused_lane;

    assign sel         = addr[OFF_W-1:3];
    assign unused_lane = addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWIN; i++) begin
                base_q[i] <= '0;
                size_q[i] <= '0;
            end
        end else if (we) begin
            if (addr[2]) size_q[sel] <= wdata;
            else         base_q[sel] <= wdata;
        end
    end

    always_comb begin
        rdata = addr[2] ? size_q[sel] : base_q[sel];
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_dec
        assign flds[w].en  = size_q[w][0];
        assign flds[w].cs  = size_q[w][4:2];
        assign flds[w].szm = size_q[w][31:24];
        assign flds[w].blo = base_q[w][31:24];
        assign flds[w].bhi = base_q[w][3:0];
    end
endmodule

// File: rtl/dcw_match.sv
module dcw_match
    import dcw_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  win_fields_t               flds [NWIN],
    input  logic [PA_W-1:0]           pa,
    output logic                      hit,
    output logic [$clog2(NWIN)-1:0]   idx,
    output logic [CS_W-1:0]           cs
);
    localparam int IDX_W = $clog2(NWIN);

    logic [NWIN-1:0] hitv;
    logic [23:0]     unused_low_bits;

    assign unused_low_bits = pa[23:0];

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign hitv[w] = flds[w].en
                      && (pa[35:32] == flds[w].bhi)
                      && ((pa[31:24] & ~flds[w].szm) == flds[w].blo);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hitv[i]) begin
                hit = 1'b1;
                idx = i[IDX_W-1:0];
            end
        end
        cs = hit ? flds[idx].cs : '0;
    end
endmodule

// File: rtl/dcw_export.sv
module dcw_export
    import dcw_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  win_fields_t                       flds [NWIN],
    input  logic                              coh,
    output logic [$clog2(NWIN+1)-1:0]         count,
    output logic [NWIN*$clog2(NWIN)-1:0]      idx_flat,
    output logic [NWIN*BYTE_W-1:0]            base_flat,
    output logic [NWIN*BYTE_W-1:0]            szm_flat,
    output logic [NWIN*ATTR_W-1:0]            attr_flat
);
    localparam int IDX_W = $clog2(NWIN);
    localparam int CNT_W = $clog2(NWIN + 1);

    logic [NWIN-1:0] unused_cs;
    for (genvar w = 0; w < NWIN; w++) begin : g_unused
        assign unused_cs[w] = ^flds[w].cs;
    end

    always_comb begin
        int n;
        n         = 0;
        idx_flat  = '0;
        base_flat = '0;
        szm_flat  = '0;
        attr_flat = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (flds[i].en && (flds[i].bhi == '0)) begin
                idx_flat[n*IDX_W +: IDX_W]    = i[IDX_W-1:0];
                base_flat[n*BYTE_W +: BYTE_W] = flds[i].blo;
                szm_flat[n*BYTE_W +: BYTE_W]  = flds[i].szm;
                attr_flat[n*ATTR_W +: ATTR_W] = cs_attr(i, coh);
                n = n + 1;
            end
        end
        count = n[CNT_W-1:0];
    end
endmodule

// File: rtl/dcw_top.sv
module dcw_top
    import dcw_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [$clog2(NWIN)+2:0]           reg_addr,
    input  logic [REG_W-1:0]                  reg_wdata,
    output logic [REG_W-1:0]                  reg_rdata,
    input  logic                              coh_en,
    input  logic [PA_W-1:0]                   lk_addr,
    output logic                              lk_miss,
    output logic [CS_W-1:0]                   lk_cs,
    output logic [ATTR_W-1:0]                 lk_attr,
    output logic [$clog2(NWIN+1)-1:0]         exp_count,
    output logic [NWIN*$clog2(NWIN)-1:0]      exp_idx,
    output logic [NWIN*BYTE_W-1:0]            exp_base,
    output logic [NWIN*BYTE_W-1:0]            exp_szm,
    output logic [NWIN*ATTR_W-1:0]            exp_attr
);
    localparam int IDX_W = $clog2(NWIN);

    win_fields_t      flds [NWIN];
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [CS_W-1:0]  m_cs;

    dcw_regs #(.NWIN(NWIN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .flds  (flds)
    );

    dcw_match #(.NWIN(NWIN)) u_match (
        .flds (flds),
        .pa   (lk_addr),
        .hit  (m_hit),
        .idx  (m_idx),
        .cs   (m_cs)
    );

    dcw_export #(.NWIN(NWIN)) u_export (
        .flds      (flds),
        .coh       (coh_en),
        .count     (exp_count),
        .idx_flat  (exp_idx),
        .base_flat (exp_base),
        .szm_flat  (exp_szm),
        .attr_flat (exp_attr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_miss <= 1'b1;
            lk_cs   <= '0;
            lk_attr <= '0;
        end else begin
            lk_miss <= !m_hit;
            lk_cs   <= m_hit ? m_cs : '0;
            lk_attr <= m_hit ? cs_attr(int'(m_idx), coh_en) : '0;
        end
    end
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker
    import dcw_pkg::*;
#(
    parameter int NWIN = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              reg_we,
    input logic [$clog2(NWIN)+2:0]           reg_addr,
    input logic [REG_W-1:0]                  reg_rdata,
    input logic                              coh_en,
    input logic                              lk_miss,
    input logic [CS_W-1:0]                   lk_cs,
    input logic [ATTR_W-1:0]                 lk_attr,
    input logic [$clog2(NWIN+1)-1:0]         exp_count,
    input logic [NWIN*$clog2(NWIN)-1:0]      exp_idx,
    input logic [NWIN*BYTE_W-1:0]            exp_base,
    input logic [NWIN*ATTR_W-1:0]            exp_attr
);
    localparam int IDX_W = $clog2(NWIN);

    // R2: with no write and a steady offset the read value holds
    a_r2_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!reg_we) && $stable(reg_addr)) |-> $stable(reg_rdata));

    // R6: a miss carries no chip select and no attribute
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_cs == '0 && lk_attr == '0));

    // R7: a hit carries exactly one cleared bit in the low nibble
    a_r7_one_cold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_miss |-> ($countones(lk_attr[3:0]) == 3 && lk_attr[7:5] == 3'b000));

    // R7: coherency bit follows the input sampled with the address
    a_r7_coh_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_miss |-> (lk_attr[COH_BIT] == $past(coh_en)));

    // R9: count never exceeds the window count
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(exp_count) <= NWIN);

    for (genvar k = 0; k < NWIN; k++) begin : g_slot
        // R9: unused slots are zero
        a_r9_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(exp_count) <= k) |->
            (exp_idx[k*IDX_W +: IDX_W] == '0 && exp_base[k*BYTE_W +: BYTE_W] == '0
             && exp_attr[k*ATTR_W +: ATTR_W] == '0));
        if (k < NWIN - 1) begin : g_ord
            // R9: filled slots are in ascending window order
            a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(exp_count) > k + 1) |->
                (exp_idx[k*IDX_W +: IDX_W] < exp_idx[(k+1)*IDX_W +: IDX_W]));
        end
    end
endmodule

bind dcw_top dcw_checker #(.NWIN(NWIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .coh_en    (coh_en),
    .lk_miss   (lk_miss),
    .lk_cs     (lk_cs),
    .lk_attr   (lk_attr),
    .exp_count (exp_count),
    .exp_idx   (exp_idx),
    .exp_base  (exp_base),
    .exp_attr  (exp_attr)
);

// File: tb/sim_dcw_top.sv
`timescale 1ns/1ps
module sim_dcw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        coh_en = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        lk_miss;
    logic [2:0]  lk_cs;
    logic [7:0]  lk_attr;
    logic [2:0]  exp_count;
    logic [7:0]  exp_idx;
    logic [31:0] exp_base;
    logic [31:0] exp_szm;
    logic [31:0] exp_attr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dcw_top #(.NWIN(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .coh_en(coh_en),
        .lk_addr(lk_addr), .lk_miss(lk_miss), .lk_cs(lk_cs), .lk_attr(lk_attr),
        .exp_count(exp_count), .exp_idx(exp_idx), .exp_base(exp_base),
        .exp_szm(exp_szm), .exp_attr(exp_attr)
    );

    // {addr, coh, miss, cs, attr}
    localparam int NV = 11;
    localparam logic [48:0] LK_VEC [NV] = '{
        {36'h0_0000_0000, 1'b0, 1'b0, 3'd2, 8'h0E},  // R3 W0 first byte
        {36'h0_0FFF_FFFF, 1'b1, 1'b0, 3'd2, 8'h1E},  // R4 W0 last byte, R7 coh
        {36'h0_1000_0000, 1'b0, 1'b0, 3'd5, 8'h0D},  // R3 W1
        {36'h0_1FFF_FFFF, 1'b0, 1'b0, 3'd5, 8'h0D},  // R4 W1 last byte
        {36'h0_2000_0000, 1'b0, 1'b1, 3'd0, 8'h00},  // R6 gap
        {36'h0_2100_0000, 1'b1, 1'b1, 3'd0, 8'h00},  // R11 unaligned W2
        {36'h1_0000_0000, 1'b0, 1'b0, 3'd7, 8'h07},  // R8 high window
        {36'h1_03FF_FFFF, 1'b1, 1'b0, 3'd7, 8'h17},  // R4 R7 high window end
        {36'h1_0400_0000, 1'b0, 1'b1, 3'd0, 8'h00},  // R4 one past end
        {36'h2_0000_0000, 1'b0, 1'b1, 3'd0, 8'h00},  // R8 nibble differs
        {36'h0_FFFF_FFFF, 1'b0, 1'b1, 3'd0, 8'h00}   // R6 no window
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic look(input logic [35:0] a, input logic c, input logic m,
                        input logic [2:0] cs, input logic [7:0] at, input string tag);
        @(negedge clk);
        lk_addr = a; coh_en = c;
        @(negedge clk);
        chk({tag, " miss"}, lk_miss, m);
        chk({tag, " cs"}, lk_cs, cs);
        chk({tag, " attr"}, lk_attr, at);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) rd(5'(i*4), 32'h0, "R1 reg reset");
        chk("R1 miss", lk_miss, 1'b1);
        chk("R1 cs", lk_cs, 3'd0);
        chk("R1 attr", lk_attr, 8'h00);
        chk("R1 count", exp_count, 3'd0);

        // configuration
        wr(5'h00, 32'h0000_0000); wr(5'h04, 32'h0F00_0009);
        wr(5'h08, 32'h1000_0000); wr(5'h0C, 32'h0F00_0015);
        wr(5'h10, 32'h2100_5A50); wr(5'h14, 32'h0100_000D);
        wr(5'h18, 32'h0000_0001); wr(5'h1F, 32'h0300_001D); // R2 low offset bits ignored
        rd(5'h04, 32'h0F00_0009, "R2 w0 size");
        rd(5'h0C, 32'h0F00_0015, "R2 w1 size");
        rd(5'h10, 32'h2100_5A50, "R2 w2 base exact");
        rd(5'h18, 32'h0000_0001, "R2 w3 base");
        rd(5'h1C, 32'h0300_001D, "R2 w3 size");

        for (int v = 0; v < NV; v++) begin
            look(LK_VEC[v][48:13], LK_VEC[v][12], LK_VEC[v][11],
                 LK_VEC[v][10:8], LK_VEC[v][7:0], $sformatf("R3 vec %0d", v));
        end

        // R9 R10 export table
        @(negedge clk); coh_en = 1'b0; #1;
        chk("R9 count", exp_count, 3'd3);
        chk("R9 idx order", exp_idx, 8'h24);
        chk("R10 base", exp_base, 32'h0021_1000);
        chk("R10 size", exp_szm, 32'h0001_0F0F);
        chk("R10 attr", exp_attr, 32'h000B_0D0E);
        coh_en = 1'b1; #1;
        chk("R10 attr coh", exp_attr, 32'h001B_1D1E);

        // disable W0
        wr(5'h04, 32'h0F00_0008);
        #1;
        chk("R9 count after disable", exp_count, 3'd2);
        chk("R9 idx repacked", exp_idx, 8'h09);
        chk("R9 base repacked", exp_base, 32'h0000_2110);
        look(36'h0_0000_0000, 1'b0, 1'b1, 3'd0, 8'h00, "R6 disabled");

        // R5 priority with overlap
        wr(5'h10, 32'h1800_0000); wr(5'h14, 32'h0000_000D);
        look(36'h0_1800_0000, 1'b0, 1'b0, 3'd5, 8'h0D, "R5 lower wins");
        wr(5'h0C, 32'h0F00_0014);
        look(36'h0_1800_0000, 1'b0, 1'b0, 3'd3, 8'h0B, "R5 next window");
        look(36'h0_1900_0000, 1'b0, 1'b1, 3'd0, 8'h00, "R4 16MiB end");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule